// File: doc/BRIEF.md
# Two-Channel Interleaved Second-Order Low-Pass Filter

This block is a fixed-point second-order recursive low-pass section. It serves two independent sample streams through one shared pipelined datapath. Each stream keeps its own pair of input history registers and its own pair of output history registers. In effect, every delay of a plain biquad is doubled. The feedback loop of a given channel therefore passes through two registers: one after the multipliers and one after the adder and saturation stage. Neither the multipliers nor the adder has to finish a whole filter step in a single clock period.

The two streams arrive on one input port, each sample marked with a channel tag and a valid strobe. At full rate the tags alternate on every cycle. Idle cycles may be inserted between samples. Each channel then sees exactly the response of a single-channel filter run on its own samples. Results leave two cycles after acceptance, carrying the tag of the sample they belong to. The coefficients are fixed at elaboration as signed Q2.16 parameters.

Top module: `iir2_pair`

## Requirements
- R1: A synchronous reset clears the output register (out_valid 0, out_y 0) and the input and output history of both channels. The first samples after reset are filtered as if every earlier sample were zero.
- R2: For each channel, y[n] = sat(floor((B0*x[n] + B1*x[n-1] + B2*x[n-2] - A1*y[n-1] - A2*y[n-2]) / 65536)).
  - x and y are signed 16-bit values and the coefficients are signed 18-bit Q2.16 values.
  - n counts only that channel's samples.
  - y[n-1] and y[n-2] are the channel's previous saturated outputs.
- R3: in_ch = 0 selects the history of channel 0 and in_ch = 1 selects the history of channel 1. Samples of one channel never change the outputs of the other.
- R4: out_ch equals the in_ch of the sample whose result is presented.
- R5: The result of a sample accepted at a rising edge (in_valid high) is presented with out_valid high after the second rising edge following it.
- R6: Results outside the 16-bit signed range are clipped to 32767 or -32768. The clipped value is also the one kept as history.
- R7: A cycle with in_valid low produces no result: out_valid stays low two edges later. It also leaves both channels' history unchanged.
- R8: Two valid samples on consecutive cycles must carry different channel tags. Full rate is therefore strict alternation 0, 1, 0, 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_ch | input | 1 | Channel tag of the input sample |
| in_x | input | SW (16) | Signed input sample |
| out_valid | output | 1 | Result present this cycle |
| out_ch | output | 1 | Channel tag of the result |
| out_y | output | SW (16) | Signed saturated filter output |

## Verification
- **Impulse on channel 0 only:** one channel gets an impulse while the other gets only zeros. The decaying response must match the reference, and the silent channel must stay exactly zero; this separates correct history selection from leakage between the banks.
- **Opposite full-scale steps:** one channel receives a positive step and the other a negative one. The step overshoot then drives both limits of the saturation, and the clipped value fed back must match.
- **Long pseudo-random runs:** these are made both at full alternation and with random idle gaps. Each output is compared against an arithmetic reference of the difference equation; the idle cycles show that gaps neither emit results nor disturb the history.
- **Reset mid-stream:** a reset in the middle of a stream must restart both channels from zero history.

// File: rtl/iir2_pair.sv
module iir2_pair #(
  parameter int SW = 16,
  parameter int CW = 18,
  parameter int CF = 16,
  parameter logic signed [CW-1:0] B0 = 18'sd4424,
  parameter logic signed [CW-1:0] B1 = 18'sd8848,
  parameter logic signed [CW-1:0] B2 = 18'sd4424,
  parameter logic signed [CW-1:0] A1 = -18'sd74908,
  parameter logic signed [CW-1:0] A2 = 18'sd27054
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_ch,
  input  logic signed [SW-1:0] in_x,
  output logic                 out_valid,
  output logic                 out_ch,
  output logic signed [SW-1:0] out_y
);
  localparam int PW = SW + CW;
  localparam int AW = PW + 3;
  localparam logic signed [AW-1:0] MAXV = {{(AW-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = ~MAXV;

  logic signed [SW-1:0] x1_q [2];
  logic signed [SW-1:0] x2_q [2];
  logic signed [SW-1:0] y1_q [2];
  logic signed [SW-1:0] y2_q [2];

  logic signed [PW-1:0] prod [5];
  logic signed [PW-1:0] p_q  [5];
  logic signed [AW-1:0] ext  [5];
  logic                 v1_q, ch1_q;

  assign prod[0] = in_x        * B0;
  assign prod[1] = x1_q[in_ch] * B1;
  assign prod[2] = x2_q[in_ch] * B2;
  assign prod[3] = y1_q[in_ch] * A1;
  assign prod[4] = y2_q[in_ch] * A2;

  for (genvar i = 0; i < 5; i++) begin : g_ext
    assign ext[i] = {{(AW-PW){p_q[i][PW-1]}}, p_q[i]};
  end

  logic signed [AW-1:0] acc, sh;
  logic signed [SW-1:0] y_sat;

  assign acc   = ext[0] + ext[1] + ext[2] - ext[3] - ext[4];
  assign sh    = acc >>> CF;
  assign y_sat = (sh > MAXV) ? MAXV[SW-1:0] :
                 (sh < MINV) ? MINV[SW-1:0] : sh[SW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 2; k++) begin
        x1_q[k] <= '0;
        x2_q[k] <= '0;
      end
      for (int k = 0; k < 5; k++) p_q[k] <= '0;
      v1_q  <= 1'b0;
      ch1_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        ch1_q        <= in_ch;
        x2_q[in_ch]  <= x1_q[in_ch];
        x1_q[in_ch]  <= in_x;
        for (int k = 0; k < 5; k++) p_q[k] <= prod[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 2; k++) begin
        y1_q[k] <= '0;
        y2_q[k] <= '0;
      end
      out_valid <= 1'b0;
      out_ch    <= 1'b0;
      out_y     <= '0;
    end else begin
      out_valid <= v1_q;
      if (v1_q) begin
        y2_q[ch1_q] <= y1_q[ch1_q];
        y1_q[ch1_q] <= y_sat;
        out_ch      <= ch1_q;
        out_y       <= y_sat;
      end
    end
  end
endmodule

module iir2_pair_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ch,
  input logic out_valid,
  input logic out_ch,
  input logic out_y_zero
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && out_y_zero));
  // R5
  latency_chk: assert property (@(posedge clk) disable iff (rst) in_valid |-> ##2 out_valid);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |-> ##2 !out_valid);
  // R4
  tag_follow_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_ch == $past(in_ch, 2)));
  // R8
  alternate_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && $past(in_valid) && !$past(rst)) |-> (in_ch != $past(in_ch)));
endmodule

bind iir2_pair iir2_pair_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ch(in_ch),
  .out_valid(out_valid), .out_ch(out_ch), .out_y_zero(out_y == '0)
);

// File: tb/iir2_pair_test.sv
`timescale 1ns/1ps
module iir2_pair_test;
  localparam int B0 = 4424, B1 = 8848, B2 = 4424, A1 = -74908, A2 = 27054;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ch = 1'b0;
  logic signed [15:0] in_x = '0;
  logic out_valid, out_ch;
  logic signed [15:0] out_y;

  always #2.5 clk = ~clk;

  iir2_pair #(.B0(18'sd4424), .B1(18'sd8848), .B2(18'sd4424),
              .A1(-18'sd74908), .A2(18'sd27054)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ch(in_ch), .in_x(in_x),
    .out_valid(out_valid), .out_ch(out_ch), .out_y(out_y));

  int checks = 0, fails = 0, cyc = 0;
  bit armed = 0;
  string lbl = "R2";
  longint rx1[2], rx2[2], ry1[2], ry2[2];
  int qy[$], qdue[$];
  bit qch[$];
  int seed = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int ref_step(bit ch, int x);
    longint acc;
    acc = B0 * longint'(x) + B1 * rx1[ch] + B2 * rx2[ch] - A1 * ry1[ch] - A2 * ry2[ch];
    acc = acc >>> 16;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    rx2[ch] = rx1[ch]; rx1[ch] = x;
    ry2[ch] = ry1[ch]; ry1[ch] = acc;
    return int'(acc);
  endfunction

  function automatic void ref_clear();
    for (int k = 0; k < 2; k++) begin rx1[k] = 0; rx2[k] = 0; ry1[k] = 0; ry2[k] = 0; end
  endfunction

  function automatic int rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >>> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  always @(negedge clk) begin
    if (armed && !rst) begin
      if (qdue.size() > 0 && qdue[0] == cyc) begin
        chk(out_valid, "R5 valid", int'(out_valid), 1);
        chk(out_ch == qch[0], "R4 tag", int'(out_ch), int'(qch[0]));
        chk(int'(out_y) == qy[0], lbl, int'(out_y), qy[0]);
        void'(qy.pop_front()); void'(qch.pop_front()); void'(qdue.pop_front());
      end else begin
        chk(!out_valid, "R7 no result", int'(out_valid), 0);
      end
    end
  end

  task automatic put(bit ch, int x);
    in_valid = 1'b1; in_ch = ch; in_x = x[15:0];
    qy.push_back(ref_step(ch, int'($signed(x[15:0]))));
    qch.push_back(ch);
    qdue.push_back(cyc + 2);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    in_valid = 1'b0; armed = 0; rst = 1'b1;
    qy.delete(); qch.delete(); qdue.delete(); ref_clear();
    repeat (3) @(negedge clk);
    chk(!out_valid && out_y == 0, "R1 reset outputs", int'(out_y), 0);
    rst = 1'b0; armed = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    ref_clear();
    @(negedge clk);
    do_reset();

    // R3: impulse on channel 0, channel 1 silent
    lbl = "R3 impulse/leak";
    put(0, 16384); put(1, 0);
    for (int i = 0; i < 40; i++) begin put(0, 0); put(1, 0); end
    idle(3);

    // R6: opposite full-scale steps drive both clip limits
    lbl = "R6 saturation";
    for (int i = 0; i < 60; i++) begin put(0, -32768); put(1, 32767); end
    idle(3);

    // R2: full-rate pseudo-random
    lbl = "R2 random";
    for (int i = 0; i < 3000; i++) begin put(0, rnd()); put(1, rnd() >>> 1); end
    idle(3);

    // R7: random idle gaps keep alternation
    lbl = "R7 gaps";
    for (int i = 0; i < 1500; i++) begin
      put(i[0], rnd());
      if (rnd() % 3 == 0) idle((rnd() & 3) + 1);
    end
    idle(3);

    // R1: reset mid-stream, then fresh impulse on both channels
    for (int i = 0; i < 20; i++) begin put(0, 30000); put(1, -30000); end
    do_reset();
    lbl = "R1 post-reset history";
    put(0, 8192); put(1, -8192);
    for (int i = 0; i < 30; i++) begin put(0, 0); put(1, 0); end

    // R2: amplitude sweep as slow ramp
    lbl = "R2 sweep";
    for (int i = -128; i < 128; i++) begin put(0, i * 256); put(1, -i * 255); end
    idle(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule